// File: doc/BRIEF.md
# Trigger-Gated Stack Readout for One Timing Channel

This block is the first buffering stage behind one channel of a time-to-digital converter. Every time measurement that arrives while the block is idle is pushed onto a circular stack. Each fiducial pulse, which marks the start of a beam revolution, pushes a marker word. The stack therefore holds a series of revolutions, each one opened by its marker.

A first-level trigger freezes the stack. The selector then pops entries newest-first into a small holding buffer. It stops once it has crossed a programmed number of markers. A marker whose revolution had no measurements is not copied, so empty revolutions vanish from the readout.

A second-level trigger then streams the holding buffer through a valid/ready output, ending with a trailer word that carries the hit count. A discard pulse throws the holding buffer away instead. In both cases the popped entries are gone, and pushing resumes from the stack pointer the readout left behind.

Top module: `trig_lifo_readout`

## Requirements
- R1: After reset `out_valid` is low and the stack is empty, so a readout of an empty stack yields only the trailer word with count 0.
- R2: While idle, a cycle with `meas_valid` pushes `{1'b0, meas_data}`, and a cycle with `fiducial` pushes the marker `{1'b1, all ones}`. When both are high in the same cycle only the marker is pushed.
- R3: The stack holds `DEPTH` (256) words. A push onto a full stack overwrites the oldest word, and the stack never stalls.
- R4: From the cycle `trig1` is taken until the readout or discard finishes, `meas_valid`, `fiducial` and further `trig1` pulses are ignored.
- R5: Popping runs newest-first and stops at whichever of these comes first:
  - N markers have been popped, where N is `rev_count` sampled with `trig1`, a value of 0 is taken as 1, and values 4 to 7 are taken as 4;
  - the stack is empty;
  - the holding buffer already holds `HOLD` (64) words.
- R6: A popped marker is copied to the holding buffer only if at least one measurement was popped since the previous marker of this readout. Otherwise it is dropped.
- R7: `trig2` after popping streams the copied words in pop order, then a trailer `{1'b1, hit count}` with `out_last` high. If `trig2` and `discard` arrive together, `trig2` wins. Both are ignored while idle.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values.
- R9: `discard` after popping ends the readout with no output word, and the popped entries are lost.
- R10: After a readout or discard, the stack continues from its current pointer, so a later readout returns the older words that were not popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_valid | input | 1 | A time measurement is present |
| meas_data | input | DW | Measurement value |
| fiducial | input | 1 | Start-of-revolution pulse, pushes a marker |
| trig1 | input | 1 | First-level trigger, freezes and starts popping |
| rev_count | input | 3 | Number of revolutions to pop, sampled with trig1 |
| trig2 | input | 1 | Second-level trigger, emits the holding buffer |
| discard | input | 1 | Drops the holding buffer |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | DW+1 | Bit DW is the flag, and the low bits carry data, a marker or the count |
| out_last | output | 1 | Marks the trailer word |

## Verification
The hardest situation to reach is a stack that has wrapped, where old revolutions have been overwritten and the remaining entries are then drained over several readouts that end on an empty stack or a full holding buffer rather than on the marker count. The bench writes 300 words in a long burst with sparse markers and then reads back repeatedly with N=4 until only the trailer comes back, comparing each word with its own model of the stack. Random rounds mix empty revolutions, dropped marker-and-hit collisions, pushes that arrive while frozen, discards and output back-pressure.

// File: rtl/trig_lifo_readout.sv
module trig_lifo_readout #(
  parameter int DW    = 16,
  parameter int DEPTH = 256,
  parameter int HOLD  = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          meas_valid,
  input  logic [DW-1:0] meas_data,
  input  logic          fiducial,
  input  logic          trig1,
  input  logic [2:0]    rev_count,
  input  logic          trig2,
  input  logic          discard,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW:0]   out_data,
  output logic          out_last
);
  localparam int AW = $clog2(DEPTH);
  localparam int HW = $clog2(HOLD);
  localparam logic [DW:0] MARK = {1'b1, {DW{1'b1}}};

  typedef enum logic [1:0] {S_IDLE, S_POP, S_WAIT, S_SEND} st_t;
  st_t state;

  logic [DW:0] mem  [DEPTH];
  logic [DW:0] hold [HOLD];
  logic [AW-1:0] ptr;
  logic [AW:0]   cnt;
  logic [HW:0]   wr, rd, hits;
  logic [2:0]    tags, nreg, nsel;
  logic          revhit;

  wire [DW:0] top      = mem[ptr - 1'b1];
  wire        pop_done = (cnt == '0) || (tags == nreg) || (wr == (HW+1)'(HOLD));
  wire        push     = (state == S_IDLE) && !trig1 && (fiducial || meas_valid);
  wire        hold_we  = (state == S_POP) && !pop_done && (!top[DW] || revhit);

  assign nsel = (rev_count == 3'd0) ? 3'd1 : (rev_count > 3'd4) ? 3'd4 : rev_count;

  assign out_valid = (state == S_SEND);
  assign out_last  = out_valid && (rd == wr);
  assign out_data  = (rd == wr) ? {1'b1, (DW)'(hits)} : hold[rd[HW-1:0]];

  always_ff @(posedge clk)
    if (push) mem[ptr] <= fiducial ? MARK : {1'b0, meas_data};

  always_ff @(posedge clk)
    if (hold_we) hold[wr[HW-1:0]] <= top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; ptr <= '0; cnt <= '0; wr <= '0; rd <= '0;
      hits <= '0; tags <= '0; nreg <= 3'd1; revhit <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (trig1) begin
            state <= S_POP; nreg <= nsel;
            wr <= '0; rd <= '0; hits <= '0; tags <= '0; revhit <= 1'b0;
          end else if (push) begin
            ptr <= ptr + 1'b1;
            if (cnt != (AW+1)'(DEPTH)) cnt <= cnt + 1'b1;
          end
        end
        S_POP: begin
          if (pop_done) state <= S_WAIT;
          else begin
            ptr <= ptr - 1'b1;
            cnt <= cnt - 1'b1;
            if (hold_we) wr <= wr + 1'b1;
            if (top[DW]) begin
              tags <= tags + 1'b1;
              revhit <= 1'b0;
            end else begin
              hits <= hits + 1'b1;
              revhit <= 1'b1;
            end
          end
        end
        S_WAIT: begin
          if (trig2) state <= S_SEND;
          else if (discard) state <= S_IDLE;
        end
        default: begin
          if (out_ready) begin
            if (rd == wr) state <= S_IDLE;
            else rd <= rd + 1'b1;
          end
        end
      endcase
    end
  end

  assert_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT || state == S_SEND) |=> $stable(ptr));
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (AW+1)'(DEPTH));
  assert_hold_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr <= (HW+1)'(HOLD)) && (tags <= nreg) && (nreg >= 3'd1) && (nreg <= 3'd4));
  assert_pop_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_POP && !pop_done) |=> (cnt == $past(cnt) - 1'b1));
  assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: tb/test_trig_lifo_readout.sv
module test_trig_lifo_readout;
  localparam int DW = 16, DEPTH = 256, HOLD = 64;
  localparam logic [DW:0] MARK = {1'b1, {DW{1'b1}}};

  logic clk = 0, rst_n = 0;
  logic meas_valid = 0, fiducial = 0, trig1 = 0, trig2 = 0, discard = 0, out_ready = 0;
  logic [DW-1:0] meas_data = '0;
  logic [2:0] rev_count = 3'd1;
  logic out_valid, out_last;
  logic [DW:0] out_data;

  trig_lifo_readout #(.DW(DW), .DEPTH(DEPTH), .HOLD(HOLD)) i_trig_lifo_readout (
    .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .meas_data(meas_data),
    .fiducial(fiducial), .trig1(trig1), .rev_count(rev_count), .trig2(trig2),
    .discard(discard), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  logic [DW:0] bm [DEPTH];
  int bptr = 0, bcnt = 0;
  logic [DW:0] ex [HOLD+1];
  int ex_n = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      summary();
    end
  end

  function automatic void model_push(input logic [DW:0] w);
    bm[bptr] = w;
    bptr = (bptr + 1) % DEPTH;
    if (bcnt < DEPTH) bcnt++;
  endfunction

  function automatic void model_pop(input int rc);
    int nn = (rc == 0) ? 1 : (rc > 4) ? 4 : rc;
    int tg = 0, hc = 0;
    bit rv = 0;
    logic [DW:0] w;
    ex_n = 0;
    while (!(bcnt == 0 || tg == nn || ex_n == HOLD)) begin
      bptr = (bptr + DEPTH - 1) % DEPTH;
      bcnt--;
      w = bm[bptr];
      if (w[DW]) begin
        tg++;
        if (rv) ex[ex_n++] = w;
        rv = 0;
      end else begin
        ex[ex_n++] = w; hc++; rv = 1;
      end
    end
    ex[ex_n++] = {1'b1, DW'(hc)};
  endfunction

  task automatic drive(input bit mv, input logic [DW-1:0] d, input bit fid);
    meas_valid = mv; meas_data = d; fiducial = fid;
    @(negedge clk);
    meas_valid = 0; fiducial = 0;
    if (fid) model_push(MARK);
    else if (mv) model_push({1'b0, d});
  endtask

  // mode 0: trig2, 1: discard, 2: trig2 and discard together
  task automatic readout(input int rc, input int mode, input bit busy_push, input string req);
    int idx = 0, t = 0;
    bit done = 0, stalled = 0;
    logic [DW:0] held = '0;
    rev_count = 3'(rc); trig1 = 1;
    @(negedge clk);
    trig1 = 0;
    model_pop(rc);
    for (int i = 0; i < 270; i++) begin
      meas_valid = busy_push && ($urandom_range(0, 2) == 0);
      fiducial = busy_push && ($urandom_range(0, 9) == 0);
      trig1 = busy_push && ($urandom_range(0, 19) == 0);
      meas_data = DW'($urandom);
      @(negedge clk);
    end
    meas_valid = 0; fiducial = 0; trig1 = 0;
    check(!out_valid, "R4 no output before trig2", out_valid, 0);
    trig2 = (mode != 1); discard = (mode != 0);
    @(negedge clk);
    trig2 = 0; discard = 0;
    if (mode == 1) begin
      for (int i = 0; i < 5; i++) begin
        check(!out_valid, "R9 discard emits nothing", out_valid, 0);
        @(negedge clk);
      end
      return;
    end
    while (!done && t < 600) begin
      bit r = ($urandom_range(0, 3) != 0);
      if (stalled) check(out_valid && out_data == held, "R8 stall holds word", out_data, held);
      out_ready = r;
      if (out_valid && r) begin
        if (idx < ex_n) check(out_data == ex[idx], req, out_data, ex[idx]);
        else check(0, req, out_data, 0);
        check(out_last == (idx == ex_n - 1), "R7 last flag", out_last, idx == ex_n - 1);
        if (out_last) done = 1;
        idx++;
      end
      stalled = out_valid && !r;
      held = out_data;
      @(negedge clk);
      t++;
    end
    out_ready = 0;
    check(done && idx == ex_n, "R7 word count", idx, ex_n);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!out_valid, "R1 reset out_valid", out_valid, 0);
    rst_n = 1;
    @(negedge clk);
    readout(1, 0, 0, "R1 empty readout");

    // R2 pushes and marker priority
    drive(0, 0, 1); drive(1, 16'h0005, 0); drive(1, 16'h0006, 0);
    drive(1, 16'h0007, 1); drive(1, 16'h0008, 0);
    readout(2, 0, 0, "R2 push and marker order");

    // R6 empty revolutions dropped
    drive(0, 0, 1); drive(0, 0, 1); drive(0, 0, 1); drive(1, 16'h0009, 0);
    readout(3, 0, 0, "R6 zero suppression");

    // R5 clamp of rev_count 0 and 7
    for (int k = 0; k < 6; k++) begin drive(0, 0, 1); drive(1, DW'(k + 16'h20), 0); end
    readout(0, 0, 0, "R5 rev_count 0 as 1");
    readout(7, 0, 0, "R5 rev_count 7 as 4");

    // R9 discard then R10 older data, R4 pushes while busy ignored
    for (int k = 0; k < 4; k++) begin drive(0, 0, 1); drive(1, DW'(k + 16'h40), 0); end
    readout(1, 1, 1, "R9 discard");
    readout(4, 0, 1, "R10 continues after discard");

    // R11-style ignore in idle, then simultaneous trig2 and discard
    trig2 = 1; discard = 1; @(negedge clk); trig2 = 0; discard = 0;
    check(!out_valid, "R7 trig2 ignored while idle", out_valid, 0);
    drive(0, 0, 1); drive(1, 16'h0077, 0);
    readout(1, 2, 0, "R7 trig2 wins over discard");

    // R3 wrap: 300 words, drain with N=4 until empty
    for (int k = 0; k < 300; k++) drive(1, DW'(k), (k % 90) == 0);
    for (int k = 0; k < 7; k++) readout(4, 0, 0, "R3 wrap and R5 hold limit");
    check(bcnt == 0, "R3 model drained", bcnt, 0);

    // random rounds
    for (int it = 0; it < 30; it++) begin
      int n = $urandom_range(0, 40);
      for (int k = 0; k < n; k++)
        drive($urandom_range(0, 2) != 0, DW'($urandom), $urandom_range(0, 5) == 0);
      readout($urandom_range(0, 7), $urandom_range(0, 2), $urandom_range(0, 1), "R5 random readout");
    end
    summary();
  end
endmodule